// File: doc/BRIEF.md
# Coprocessor Status and Control Register File

This block holds the control and status state of an attached coprocessor, as seen from a host bus. Software changes the status flags by writing a command word. Each flag owns one bit that clears it and one bit that sets it. A command bit written as 0 leaves its flag alone, so several flags can change in a single write without a read-modify-write sequence. The block drives the coprocessor halt line and a sticky interrupt request line. A raise input lets the coprocessor side assert the interrupt request directly.

The same register file holds the local memory address, the external memory address, the read length and the program counter registers. The address and program counter registers force alignment by masking the stored value after the byte-enable merge. The block does not run the coprocessor, schedule delayed interrupts or move any data.

Top module: `cop_status_regs`

## Requirements
- R1: Command bit 0 clears halt and command bit 1 sets halt. Halt reads at status bit 0 and drives `halt_o`.
- R2: Command bit 2 clears the broke flag, which reads at status bit 1. No command bit sets broke.
- R3: Command bit 3 clears the interrupt request and command bit 4 sets it. The request drives `irq_o` and keeps its value until changed. A cycle with `irq_raise_i` high sets it, and the raise wins over a clear in the same cycle.
- R4: Command bits 5 and 6 clear and set single-step, which reads at status bit 5. Command bits 7 and 8 clear and set interrupt-on-break, which reads at status bit 6.
- R5: Signal flag k (k = 0..NUM_SIG-1) is cleared by command bit 9+2k and set by command bit 10+2k. It reads at status bit 7+k, so flag 7 reads at bit 14.
- R6: When both bits of a clear/set pair are 1 in one write, that flag keeps its previous value.
- R7: After reset, status reads 1 (halted, all other flags clear), `irq_o` is 0, read length reads 0xFF8, and the two address registers and the program counter read 0.
- R8: The local address register keeps only the bits in mask 0x1FF8. The external address register keeps only the bits in mask 0xFFFFF8.
- R9: The program counter keeps only the bits in mask 0xFFC.
- R10: Writes update only the bytes whose byte-enable bit is 1, and the alignment mask is applied after the byte merge. For a command write, command bits in disabled bytes are treated as 0.
- R11: The register index map is 0 local address, 1 external address, 2 read length, 3 status (a write is a command), 4 program counter. Other indices read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe |
| bus_addr_i | input | ADDR_W | Register index for both read and write |
| bus_wdata_i | input | 32 | Write data |
| bus_be_i | input | 4 | Byte enables for the write |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| irq_raise_i | input | 1 | Coprocessor-side pulse that sets the interrupt request |
| irq_o | output | 1 | Sticky interrupt request |
| halt_o | output | 1 | Coprocessor halt |

## Verification
The bench builds the block with its default parameters: all eight signal flags, the raise-wins interrupt variant, and the default alignment masks and read-length reset value. With all eight signal flags present, the highest command pair (bits 23 and 24) and status bit 14 are exercised. The raise-wins variant makes the contest between a raise pulse and a clear command in the same cycle observable. The all-ones write patterns expose every bit that the alignment masks remove, and partial byte enables separate the byte merge from the masking.

// File: rtl/cop_stat_pkg.sv
package cop_stat_pkg;

   localparam int WORD_W = 32;
   localparam int BE_W   = WORD_W / 8;

   // register indices
   localparam int RG_LMEM  = 0;
   localparam int RG_XMEM  = 1;
   localparam int RG_RDLEN = 2;
   localparam int RG_STAT  = 3;
   localparam int RG_PC    = 4;
   localparam int NUM_REGS = 5;

   // command word bit positions
   localparam int CB_HALT_CLR  = 0;
   localparam int CB_HALT_SET  = 1;
   localparam int CB_BROKE_CLR = 2;
   localparam int CB_IRQ_CLR   = 3;
   localparam int CB_IRQ_SET   = 4;
   localparam int CB_STEP_CLR  = 5;
   localparam int CB_STEP_SET  = 6;
   localparam int CB_IBRK_CLR  = 7;
   localparam int CB_IBRK_SET  = 8;
   localparam int CB_SIG_BASE  = 9;

   // status read bit positions
   localparam int SB_HALT     = 0;
   localparam int SB_BROKE    = 1;
   localparam int SB_STEP     = 5;
   localparam int SB_IBRK     = 6;
   localparam int SB_SIG_BASE = 7;

   function automatic logic [WORD_W-1:0] be_expand(input logic [BE_W-1:0] be);
      logic [WORD_W-1:0] m;
      for (int i = 0; i < BE_W; i++) m[i*8 +: 8] = {8{be[i]}};
      return m;
   endfunction

   function automatic logic [WORD_W-1:0] byte_merge(input logic [WORD_W-1:0] old_v,
                                                    input logic [WORD_W-1:0] new_v,
                                                    input logic [BE_W-1:0]   be);
      logic [WORD_W-1:0] m;
      m = be_expand(be);
      return (old_v & ~m) | (new_v & m);
   endfunction

endpackage

// File: rtl/cop_pair_flag.sv
module cop_pair_flag #(
   parameter bit RST_VAL = 1'b0,
   parameter bit HAS_SET = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic set_i,
   output logic q_o
);

   logic set_eff;
   assign set_eff = set_i & HAS_SET;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 q_o <= RST_VAL;
      else if (clr_i && !set_eff)  q_o <= 1'b0;
      else if (set_eff && !clr_i)  q_o <= 1'b1;
   end

   // R5 / R1 / R4: a lone clear bit drops the flag
   p_pair_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !set_i) |=> !q_o);

   // R5: a lone set bit raises the flag when the flag has a set bit
   p_pair_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i && !clr_i && HAS_SET) |=> q_o);

   // R6: both bits of the pair leave the flag unchanged
   p_pair_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && set_i) |=> $stable(q_o));

endmodule

// File: rtl/cop_mask_reg.sv
module cop_mask_reg
   import cop_stat_pkg::*;
#(
   parameter logic [WORD_W-1:0] MASK    = '1,
   parameter logic [WORD_W-1:0] RST_VAL = '0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              we_i,
   input  logic [WORD_W-1:0] wdata_i,
   input  logic [BE_W-1:0]   be_i,
   output logic [WORD_W-1:0] q_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q_o <= RST_VAL & MASK;
      else if (we_i) q_o <= byte_merge(q_o, wdata_i, be_i) & MASK;
   end

   // R8 / R9: after a full-word write the stored value is the data with the mask applied
   p_full_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && (&be_i)) |=> (q_o == ($past(wdata_i) & MASK)));

   // R10: bytes with a low enable keep their previous contents
   p_byte_keep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i |=> ((q_o & ~be_expand($past(be_i))) == ($past(q_o) & ~be_expand($past(be_i)))));

endmodule

// File: rtl/cop_status_regs.sv
module cop_status_regs
   import cop_stat_pkg::*;
#(
   parameter int                ADDR_W         = 3,
   parameter int                NUM_SIG        = 8,
   parameter bit                IRQ_RAISE_WINS = 1'b1,
   parameter logic [WORD_W-1:0] LMEM_MASK      = 32'h0000_1FF8,
   parameter logic [WORD_W-1:0] XMEM_MASK      = 32'h00FF_FFF8,
   parameter logic [WORD_W-1:0] PC_MASK        = 32'h0000_0FFC,
   parameter logic [WORD_W-1:0] RDLEN_RST      = 32'h0000_0FF8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_we_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [WORD_W-1:0] bus_wdata_i,
   input  logic [BE_W-1:0]   bus_be_i,
   output logic [WORD_W-1:0] bus_rdata_o,
   input  logic              irq_raise_i,
   output logic              irq_o,
   output logic              halt_o
);

   localparam int CMD_TOP  = CB_SIG_BASE + 2 * NUM_SIG - 1;
   localparam int STAT_TOP = SB_SIG_BASE + NUM_SIG - 1;

   if (NUM_SIG < 1 || NUM_SIG > 8) begin : g_bad_sig
      $error("NUM_SIG must lie between 1 and 8");
   end
   if ((1 << ADDR_W) < NUM_REGS) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end
   if (CMD_TOP >= WORD_W || STAT_TOP >= WORD_W) begin : g_bad_width
      $error("flag layout exceeds the word width");
   end

   // ---------------- decode ----------------
   logic we_lmem, we_xmem, we_len, we_stat, we_pc;
   assign we_lmem = bus_we_i && (bus_addr_i == ADDR_W'(RG_LMEM));
   assign we_xmem = bus_we_i && (bus_addr_i == ADDR_W'(RG_XMEM));
   assign we_len  = bus_we_i && (bus_addr_i == ADDR_W'(RG_RDLEN));
   assign we_stat = bus_we_i && (bus_addr_i == ADDR_W'(RG_STAT));
   assign we_pc   = bus_we_i && (bus_addr_i == ADDR_W'(RG_PC));

   logic [WORD_W-1:0] cmd;
   assign cmd = we_stat ? (bus_wdata_i & be_expand(bus_be_i)) : '0;

   // ---------------- data registers ----------------
   logic [WORD_W-1:0] lmem_q, xmem_q, len_q, pc_q;

   cop_mask_reg #(.MASK(LMEM_MASK), .RST_VAL('0)) u_lmem (
      .clk_i, .rst_ni, .we_i(we_lmem), .wdata_i(bus_wdata_i), .be_i(bus_be_i), .q_o(lmem_q));
   cop_mask_reg #(.MASK(XMEM_MASK), .RST_VAL('0)) u_xmem (
      .clk_i, .rst_ni, .we_i(we_xmem), .wdata_i(bus_wdata_i), .be_i(bus_be_i), .q_o(xmem_q));
   cop_mask_reg #(.MASK('1), .RST_VAL(RDLEN_RST)) u_len (
      .clk_i, .rst_ni, .we_i(we_len), .wdata_i(bus_wdata_i), .be_i(bus_be_i), .q_o(len_q));
   cop_mask_reg #(.MASK(PC_MASK), .RST_VAL('0)) u_pc (
      .clk_i, .rst_ni, .we_i(we_pc), .wdata_i(bus_wdata_i), .be_i(bus_be_i), .q_o(pc_q));

   // ---------------- status flags ----------------
   logic halt_q, broke_q, step_q, ibrk_q;
   logic [NUM_SIG-1:0] sig_q;

   cop_pair_flag #(.RST_VAL(1'b1), .HAS_SET(1'b1)) u_halt (
      .clk_i, .rst_ni, .clr_i(cmd[CB_HALT_CLR]), .set_i(cmd[CB_HALT_SET]), .q_o(halt_q));
   cop_pair_flag #(.RST_VAL(1'b0), .HAS_SET(1'b0)) u_broke (
      .clk_i, .rst_ni, .clr_i(cmd[CB_BROKE_CLR]), .set_i(1'b0), .q_o(broke_q));
   cop_pair_flag #(.RST_VAL(1'b0), .HAS_SET(1'b1)) u_step (
      .clk_i, .rst_ni, .clr_i(cmd[CB_STEP_CLR]), .set_i(cmd[CB_STEP_SET]), .q_o(step_q));
   cop_pair_flag #(.RST_VAL(1'b0), .HAS_SET(1'b1)) u_ibrk (
      .clk_i, .rst_ni, .clr_i(cmd[CB_IBRK_CLR]), .set_i(cmd[CB_IBRK_SET]), .q_o(ibrk_q));

   for (genvar k = 0; k < NUM_SIG; k++) begin : g_sig
      cop_pair_flag #(.RST_VAL(1'b0), .HAS_SET(1'b1)) u_sig (
         .clk_i, .rst_ni,
         .clr_i(cmd[CB_SIG_BASE + 2*k]),
         .set_i(cmd[CB_SIG_BASE + 2*k + 1]),
         .q_o(sig_q[k]));
   end

   assign halt_o = halt_q;

   // ---------------- interrupt request ----------------
   logic irq_clr, irq_set;
   assign irq_clr = cmd[CB_IRQ_CLR] && !cmd[CB_IRQ_SET];
   assign irq_set = cmd[CB_IRQ_SET] && !cmd[CB_IRQ_CLR];

   if (IRQ_RAISE_WINS) begin : g_irq_raise_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                     irq_o <= 1'b0;
         else if (irq_raise_i || irq_set) irq_o <= 1'b1;
         else if (irq_clr)                irq_o <= 1'b0;
      end
      // R3: a raise pulse always leaves the request asserted
      p_raise_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         irq_raise_i |=> irq_o);
   end else begin : g_irq_clear_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                     irq_o <= 1'b0;
         else if (irq_clr)                irq_o <= 1'b0;
         else if (irq_raise_i || irq_set) irq_o <= 1'b1;
      end
   end

   // R3: with neither a raise nor a command to it, the request is sticky
   p_irq_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!irq_raise_i && !(bus_we_i && bus_addr_i == ADDR_W'(RG_STAT))) |=> $stable(irq_o));

   // R1: a lone halt-clear command releases the halt line
   p_halt_release_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_we_i && bus_addr_i == ADDR_W'(RG_STAT) && bus_be_i[0] &&
       bus_wdata_i[CB_HALT_CLR] && !bus_wdata_i[CB_HALT_SET]) |=> !halt_o);

   // R2: broke can never rise
   p_broke_no_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !broke_q |=> !broke_q);

   // ---------------- read mux ----------------
   logic [WORD_W-1:0] stat_rd;
   always_comb begin
      stat_rd = '0;
      stat_rd[SB_HALT]  = halt_q;
      stat_rd[SB_BROKE] = broke_q;
      stat_rd[SB_STEP]  = step_q;
      stat_rd[SB_IBRK]  = ibrk_q;
      stat_rd[STAT_TOP:SB_SIG_BASE] = sig_q;
   end

   always_comb begin
      unique case (int'(bus_addr_i))
         RG_LMEM:  bus_rdata_o = lmem_q;
         RG_XMEM:  bus_rdata_o = xmem_q;
         RG_RDLEN: bus_rdata_o = len_q;
         RG_STAT:  bus_rdata_o = stat_rd;
         RG_PC:    bus_rdata_o = pc_q;
         default:  bus_rdata_o = '0;
      endcase
   end

   // R11: an index outside the map reads zero
   p_unmapped_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(bus_addr_i) >= NUM_REGS) |-> (bus_rdata_o == '0));

endmodule

// File: tb/cop_status_regs_test.sv
module cop_status_regs_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_rdata;
   logic        irq_raise = 1'b0;
   logic        irq_o, halt_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cop_status_regs uut (
      .clk_i(clk), .rst_ni(rst_n), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
      .bus_wdata_i(bus_wdata), .bus_be_i(bus_be), .bus_rdata_o(bus_rdata),
      .irq_raise_i(irq_raise), .irq_o(irq_o), .halt_o(halt_o));

   // ---------------- reference model ----------------
   logic [31:0] m_lmem = 0, m_xmem = 0, m_len = 32'hFF8, m_pc = 0;
   logic        m_halt = 1, m_broke = 0, m_step = 0, m_ibrk = 0, m_irq = 0;
   logic [7:0]  m_sig = 0;

   function automatic logic [31:0] ref_merge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
      logic [31:0] r = o;
      for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = n[b*8 +: 8];
      return r;
   endfunction

   function automatic logic [31:0] ref_read(logic [2:0] a);
      logic [31:0] s = 0;
      case (a)
         3'd0: return m_lmem;
         3'd1: return m_xmem;
         3'd2: return m_len;
         3'd3: begin
            s[0] = m_halt; s[1] = m_broke; s[5] = m_step; s[6] = m_ibrk;
            for (int k = 0; k < 8; k++) s[7+k] = m_sig[k];
            return s;
         end
         3'd4: return m_pc;
         default: return 0;
      endcase
   endfunction

   task automatic ref_cmd(logic [31:0] c);
      if (c[0] && !c[1]) m_halt = 0;
      if (c[1] && !c[0]) m_halt = 1;
      if (c[2]) m_broke = 0;
      if (c[3] && !c[4]) m_irq = 0;
      if (c[4] && !c[3]) m_irq = 1;
      if (c[5] && !c[6]) m_step = 0;
      if (c[6] && !c[5]) m_step = 1;
      if (c[7] && !c[8]) m_ibrk = 0;
      if (c[8] && !c[7]) m_ibrk = 1;
      for (int k = 0; k < 8; k++) begin
         if (c[9+2*k] && !c[10+2*k]) m_sig[k] = 0;
         if (c[10+2*k] && !c[9+2*k]) m_sig[k] = 1;
      end
   endtask

   task automatic bus_wr(logic [2:0] a, logic [31:0] d, logic [3:0] be, logic raise);
      logic [31:0] c;
      @(negedge clk);
      bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = be; irq_raise = raise;
      @(posedge clk);
      case (a)
         3'd0: m_lmem = ref_merge(m_lmem, d, be) & 32'h1FF8;
         3'd1: m_xmem = ref_merge(m_xmem, d, be) & 32'hFFFFF8;
         3'd2: m_len  = ref_merge(m_len, d, be);
         3'd3: begin
            c = ref_merge(32'h0, d, be);
            ref_cmd(c);
         end
         3'd4: m_pc   = ref_merge(m_pc, d, be) & 32'hFFC;
         default: ;
      endcase
      if (raise) m_irq = 1;
      @(negedge clk);
      bus_we = 0; irq_raise = 0;
   endtask

   task automatic pulse_raise();
      @(negedge clk);
      irq_raise = 1;
      @(posedge clk);
      m_irq = 1;
      @(negedge clk);
      irq_raise = 0;
   endtask

   task automatic chk_rd(logic [2:0] a, string req);
      logic [31:0] e;
      @(negedge clk);
      bus_addr = a;
      #1;
      e = ref_read(a);
      n_chk++;
      if (bus_rdata !== e) begin
         n_fail++;
         $display("FAIL %s reg %0d: got %h expected %h", req, a, bus_rdata, e);
      end
   endtask

   // every cycle: halt and interrupt lines against the model (R1, R3)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_chk++;
         if (halt_o !== m_halt || irq_o !== m_irq) begin
            n_fail++;
            $display("FAIL R1/R3 lines: halt=%b irq=%b expected halt=%b irq=%b",
                     halt_o, irq_o, m_halt, m_irq);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;

      // R7: reset values
      for (int a = 0; a < 5; a++) chk_rd(3'(a), "R7");

      // R1: halt pair
      bus_wr(3'd3, 32'h1, 4'hF, 0);       chk_rd(3'd3, "R1");
      bus_wr(3'd3, 32'h2, 4'hF, 0);       chk_rd(3'd3, "R1");
      // R6: both halt bits keep halt set
      bus_wr(3'd3, 32'h3, 4'hF, 0);       chk_rd(3'd3, "R6");
      bus_wr(3'd3, 32'h1, 4'hF, 0);
      bus_wr(3'd3, 32'h3, 4'hF, 0);       chk_rd(3'd3, "R6");

      // R4: single-step and interrupt-on-break
      bus_wr(3'd3, 32'h140, 4'hF, 0);     chk_rd(3'd3, "R4");
      bus_wr(3'd3, 32'h020, 4'hF, 0);     chk_rd(3'd3, "R4");
      bus_wr(3'd3, 32'h180, 4'hF, 0);     chk_rd(3'd3, "R6");
      bus_wr(3'd3, 32'h080, 4'hF, 0);     chk_rd(3'd3, "R4");

      // R5: all signal flags set, then selective clears, flag 7 at bit 14
      bus_wr(3'd3, 32'h0155_5400, 4'hF, 0); chk_rd(3'd3, "R5");
      bus_wr(3'd3, 32'h0000_8000, 4'hF, 0); chk_rd(3'd3, "R5");
      bus_wr(3'd3, 32'h0080_0000, 4'hF, 0); chk_rd(3'd3, "R5");
      bus_wr(3'd3, 32'h0018_0000, 4'hF, 0); chk_rd(3'd3, "R6");
      bus_wr(3'd3, 32'h0008_0000, 4'hF, 0); chk_rd(3'd3, "R5");

      // R2: broke clear has no visible set effect
      bus_wr(3'd3, 32'h4, 4'hF, 0);       chk_rd(3'd3, "R2");

      // R3: interrupt request pair, sticky, raise input
      bus_wr(3'd3, 32'h10, 4'hF, 0);      chk_rd(3'd3, "R3");
      repeat (3) @(negedge clk);
      bus_wr(3'd3, 32'h08, 4'hF, 0);
      bus_wr(3'd3, 32'h18, 4'hF, 0);      chk_rd(3'd3, "R6");
      pulse_raise();
      repeat (2) @(negedge clk);
      bus_wr(3'd3, 32'h08, 4'hF, 1);      chk_rd(3'd3, "R3");
      bus_wr(3'd3, 32'h08, 4'hF, 0);

      // R8, R9: alignment masks
      bus_wr(3'd0, 32'hFFFF_FFFF, 4'hF, 0); chk_rd(3'd0, "R8");
      bus_wr(3'd1, 32'hFFFF_FFFF, 4'hF, 0); chk_rd(3'd1, "R8");
      bus_wr(3'd4, 32'hFFFF_FFFF, 4'hF, 0); chk_rd(3'd4, "R9");
      bus_wr(3'd1, 32'h0012_3457, 4'hF, 0); chk_rd(3'd1, "R8");

      // R10: byte enables
      bus_wr(3'd2, 32'h1234_5678, 4'b0010, 0); chk_rd(3'd2, "R10");
      bus_wr(3'd4, 32'h0000_0003, 4'b0001, 0); chk_rd(3'd4, "R10");
      bus_wr(3'd0, 32'h0000_0A0F, 4'b0001, 0); chk_rd(3'd0, "R10");
      bus_wr(3'd3, 32'h0000_0401, 4'b0001, 0); chk_rd(3'd3, "R10");
      bus_wr(3'd3, 32'h0000_0010, 4'b1110, 0); chk_rd(3'd3, "R10");

      // R11: unmapped indices
      bus_wr(3'd7, 32'hFFFF_FFFF, 4'hF, 0); chk_rd(3'd7, "R11");
      chk_rd(3'd5, "R11");
      for (int a = 0; a < 5; a++) chk_rd(3'(a), "R11");

      repeat (2) @(negedge clk);
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule